// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This unit forms the memory address for a load or store and the new value for the base register. It takes a base register value and an offset, and it combines them under one of three indexing modes. In offset mode the adjusted address is used and the base is left alone. In pre-indexed mode the adjusted address is used and is also written back to the base. In post-indexed mode the base is used unchanged as the address, and the adjusted value is written back.

The offset comes from one of three sources. It can be a 12-bit immediate. It can be an index register. It can be that index register shifted left by 0 to 3 places. A separate direction bit chooses whether the offset is added to the base or subtracted from it. All arithmetic wraps modulo 2^32. The parameter `REG_OUT` selects the output path: by default the outputs pass through one register stage that reset clears, and with `REG_OUT` set to 0 the unit is purely combinational.

The datapath is a short chain of three parts: offset generation, then add or subtract, then mode selection. The mode selector is a case over the enumerated indexing modes. There are four modes: OFS, PRE, POST and RSV. Each mode fixes which value goes to the address, which value goes to the writeback port, and whether writeback is enabled. No mode depends on the one before it, so the unit makes no transitions between modes. The register stage only holds the last selection.

Top module: `agu_top`

## Requirements
- R1: Offset mode (`mode_i` = 2'b00): `ea_o` = base ± offset, `wb_val_o` = base unchanged, `wb_en_o` = 0.
- R2: Pre-indexed mode (`mode_i` = 2'b01): `ea_o` and `wb_val_o` both equal base ± offset, and `wb_en_o` = 1.
- R3: Post-indexed mode (`mode_i` = 2'b10): `ea_o` = base unchanged, `wb_val_o` = base ± offset, and `wb_en_o` = 1.
- R4: Immediate source (`off_src_i` = 2'b00): the offset is `imm_i` zero-extended from 12 to 32 bits. `idx_i` and `shamt_i` have no effect.
- R5: Register source (`off_src_i` = 2'b01): the offset is `idx_i` unshifted. `shamt_i` and `imm_i` have no effect.
- R6: Shifted register source (`off_src_i` = 2'b10 or 2'b11): the offset is `idx_i` shifted left by `shamt_i` (0 to 3). Bits shifted past bit 31 are discarded.
- R7: `add_i` = 1 adds the offset and `add_i` = 0 subtracts it. The result wraps modulo 2^32 and no overflow indication is produced.
- R8: The reserved mode (`mode_i` = 2'b11) behaves exactly like offset mode.
- R9: With `REG_OUT` = 1 (the default), outputs reflect the inputs sampled at the previous rising clock edge. While `rst_n` is low, all outputs are 0.
- R10: `wb_en_o` is 1 only in pre-indexed and post-indexed modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| base_i | input | 32 | Base register value |
| off_src_i | input | 2 | Offset source: 00 immediate, 01 register, 1x shifted register |
| imm_i | input | 12 | Unsigned immediate offset |
| idx_i | input | 32 | Index register value |
| shamt_i | input | 2 | Left-shift amount for the shifted register source |
| add_i | input | 1 | 1 adds the offset, 0 subtracts it |
| mode_i | input | 2 | Indexing mode: 00 offset, 01 pre, 10 post, 11 reserved (as offset) |
| ea_o | output | 32 | Effective address |
| wb_val_o | output | 32 | Value for base register writeback |
| wb_en_o | output | 1 | Writeback enable |

## Verification
The assertions assume that every input is a known 0/1 value at each rising edge once reset is released. They also assume that the output register stage is present, so each output can be paired with the inputs captured one edge earlier. The bench drives all inputs on the falling edge and holds them through the next rising edge. It keeps every input defined from time zero, so each captured set is a whole, stable vector. The stimulus covers every mode and source encoding, including the reserved codes, so the properties see each branch.

// File: rtl/agu_pkg.sv
package agu_pkg;

    // Indexing modes; the two-bit code is part of the port contract.
    typedef enum logic [1:0] {
        AGU_MODE_OFS  = 2'b00,
        AGU_MODE_PRE  = 2'b01,
        AGU_MODE_POST = 2'b10,
        AGU_MODE_RSV  = 2'b11
    } agu_mode_e;

    // Offset sources; both 1x codes select the shifted index register.
    typedef enum logic [1:0] {
        AGU_SRC_IMM  = 2'b00,
        AGU_SRC_REG  = 2'b01,
        AGU_SRC_SHL  = 2'b10,
        AGU_SRC_SHL2 = 2'b11
    } agu_src_e;

endpackage

// File: rtl/agu_offset_gen.sv
module agu_offset_gen
    import agu_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IMM_W = 12,
    parameter int SH_W  = 2
) (
    input  logic [1:0]      src_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic [XLEN-1:0] idx_i,
    input  logic [SH_W-1:0] shamt_i,
    output logic [XLEN-1:0] off_o
);
    localparam int PAD_W = XLEN - IMM_W;

    logic [XLEN-1:0] imm_ext;
    logic [XLEN-1:0] idx_shl;

    assign imm_ext = {{PAD_W{1'b0}}, imm_i};
    // Width of the assignment target truncates bits shifted past the top.
    assign idx_shl = idx_i << shamt_i;

    always_comb begin
        off_o = '0;
        unique case (agu_src_e'(src_i))
            AGU_SRC_IMM:  off_o = imm_ext;
            AGU_SRC_REG:  off_o = idx_i;
            AGU_SRC_SHL:  off_o = idx_shl;
            AGU_SRC_SHL2: off_o = idx_shl;
        endcase
    end

endmodule

// File: rtl/agu_adder.sv
module agu_adder #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] base_i,
    input  logic [XLEN-1:0] off_i,
    input  logic            add_i,
    output logic [XLEN-1:0] sum_o
);
    logic [XLEN-1:0] off_eff;
    logic [XLEN-1:0] cin;

    // One adder serves both directions: subtract as base + ~off + 1.
    assign off_eff = add_i ? off_i : ~off_i;
    assign cin     = {{(XLEN-1){1'b0}}, ~add_i};
    assign sum_o   = base_i + off_eff + cin;

endmodule

// File: rtl/agu_mode_sel.sv
module agu_mode_sel
    import agu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [1:0]      mode_i,
    input  logic [XLEN-1:0] base_i,
    input  logic [XLEN-1:0] sum_i,
    output logic [XLEN-1:0] ea_o,
    output logic [XLEN-1:0] wb_val_o,
    output logic            wb_en_o
);
    always_comb begin
        ea_o     = base_i;
        wb_val_o = base_i;
        wb_en_o  = 1'b0;
        unique case (agu_mode_e'(mode_i))
            AGU_MODE_OFS: begin
                ea_o = sum_i;
            end
            AGU_MODE_PRE: begin
                ea_o     = sum_i;
                wb_val_o = sum_i;
                wb_en_o  = 1'b1;
            end
            AGU_MODE_POST: begin
                ea_o     = base_i;
                wb_val_o = sum_i;
                wb_en_o  = 1'b1;
            end
            AGU_MODE_RSV: begin
                ea_o = sum_i;
            end
        endcase
    end

endmodule

// File: rtl/agu_top.sv
module agu_top #(
    parameter int XLEN    = 32,
    parameter int IMM_W   = 12,
    parameter int SH_W    = 2,
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [XLEN-1:0]  base_i,
    input  logic [1:0]       off_src_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic [XLEN-1:0]  idx_i,
    input  logic [SH_W-1:0]  shamt_i,
    input  logic             add_i,
    input  logic [1:0]       mode_i,
    output logic [XLEN-1:0]  ea_o,
    output logic [XLEN-1:0]  wb_val_o,
    output logic             wb_en_o
);
    logic [XLEN-1:0] off_w;
    logic [XLEN-1:0] sum_w;
    logic [XLEN-1:0] ea_w;
    logic [XLEN-1:0] wb_w;
    logic            wb_en_w;

    agu_offset_gen #(
        .XLEN (XLEN),
        .IMM_W(IMM_W),
        .SH_W (SH_W)
    ) i_offset_gen (
        .src_i  (off_src_i),
        .imm_i  (imm_i),
        .idx_i  (idx_i),
        .shamt_i(shamt_i),
        .off_o  (off_w)
    );

    agu_adder #(
        .XLEN(XLEN)
    ) i_adder (
        .base_i(base_i),
        .off_i (off_w),
        .add_i (add_i),
        .sum_o (sum_w)
    );

    agu_mode_sel #(
        .XLEN(XLEN)
    ) i_mode_sel (
        .mode_i  (mode_i),
        .base_i  (base_i),
        .sum_i   (sum_w),
        .ea_o    (ea_w),
        .wb_val_o(wb_w),
        .wb_en_o (wb_en_w)
    );

    generate
        if (REG_OUT) begin : g_reg_out
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    ea_o     <= '0;
                    wb_val_o <= '0;
                    wb_en_o  <= 1'b0;
                end else begin
                    ea_o     <= ea_w;
                    wb_val_o <= wb_w;
                    wb_en_o  <= wb_en_w;
                end
            end
        end else begin : g_comb_out
            assign ea_o     = ea_w;
            assign wb_val_o = wb_w;
            assign wb_en_o  = wb_en_w;
        end
    endgenerate

endmodule

// File: rtl/agu_checker.sv
module agu_checker #(
    parameter int XLEN    = 32,
    parameter int IMM_W   = 12,
    parameter int SH_W    = 2,
    parameter bit REG_OUT = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [XLEN-1:0]  base_i,
    input logic [1:0]       off_src_i,
    input logic [IMM_W-1:0] imm_i,
    input logic [XLEN-1:0]  idx_i,
    input logic [SH_W-1:0]  shamt_i,
    input logic             add_i,
    input logic [1:0]       mode_i,
    input logic [XLEN-1:0]  ea_o,
    input logic [XLEN-1:0]  wb_val_o,
    input logic             wb_en_o
);
    logic [XLEN-1:0]  c_base;
    logic [1:0]       c_src;
    logic [IMM_W-1:0] c_imm;
    logic [XLEN-1:0]  c_idx;
    logic [SH_W-1:0]  c_sh;
    logic             c_add;
    logic [1:0]       c_mode;
    logic             vld;

    // Copies of the inputs aligned with the outputs they produced.
    generate
        if (REG_OUT) begin : g_cap
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    c_base <= '0; c_src <= '0; c_imm <= '0; c_idx <= '0;
                    c_sh   <= '0; c_add <= 1'b0; c_mode <= '0; vld <= 1'b0;
                end else begin
                    c_base <= base_i; c_src <= off_src_i; c_imm <= imm_i;
                    c_idx  <= idx_i;  c_sh  <= shamt_i;   c_add <= add_i;
                    c_mode <= mode_i; vld   <= 1'b1;
                end
            end
        end else begin : g_cap
            assign c_base = base_i; assign c_src = off_src_i;
            assign c_imm  = imm_i;  assign c_idx = idx_i;
            assign c_sh   = shamt_i; assign c_add = add_i;
            assign c_mode = mode_i; assign vld   = rst_n;
        end
    endgenerate

    assert_wb_en_modes_R10: assert property (@(posedge clk) disable iff (!rst_n || !vld)
        wb_en_o == (c_mode == 2'b01 || c_mode == 2'b10));

    assert_post_ea_base_R3: assert property (@(posedge clk) disable iff (!rst_n || !vld)
        (c_mode == 2'b10) |-> (ea_o == c_base));

    assert_pre_ea_eq_wb_R2: assert property (@(posedge clk) disable iff (!rst_n || !vld)
        (c_mode == 2'b01) |-> (ea_o == wb_val_o));

    assert_ofs_base_kept_R1: assert property (@(posedge clk) disable iff (!rst_n || !vld)
        (c_mode == 2'b00 || c_mode == 2'b11) |-> (wb_val_o == c_base && !wb_en_o));

    assert_imm_zero_ext_R4: assert property (@(posedge clk) disable iff (!rst_n || !vld)
        (c_mode == 2'b00 && c_src == 2'b00 && c_add) |-> (ea_o - c_base == XLEN'(c_imm)));

    assert_sub_inverse_R7: assert property (@(posedge clk) disable iff (!rst_n || !vld)
        (c_mode == 2'b01 && c_src == 2'b01 && !c_add) |-> (ea_o + c_idx == c_base));

    assert_shift_offset_R6: assert property (@(posedge clk) disable iff (!rst_n || !vld)
        (c_mode == 2'b10 && c_src[1] && c_add) |-> (wb_val_o - c_base == (c_idx << c_sh)));

endmodule

bind agu_top agu_checker #(
    .XLEN   (XLEN),
    .IMM_W  (IMM_W),
    .SH_W   (SH_W),
    .REG_OUT(REG_OUT)
) i_agu_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .base_i   (base_i),
    .off_src_i(off_src_i),
    .imm_i    (imm_i),
    .idx_i    (idx_i),
    .shamt_i  (shamt_i),
    .add_i    (add_i),
    .mode_i   (mode_i),
    .ea_o     (ea_o),
    .wb_val_o (wb_val_o),
    .wb_en_o  (wb_en_o)
);

// File: tb/test_agu_top.sv
`timescale 1ns/1ps
module test_agu_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] base_i = '0;
    logic [1:0]  off_src_i = '0;
    logic [11:0] imm_i = '0;
    logic [31:0] idx_i = '0;
    logic [1:0]  shamt_i = '0;
    logic        add_i = 1'b1;
    logic [1:0]  mode_i = '0;
    logic [31:0] ea_o;
    logic [31:0] wb_val_o;
    logic        wb_en_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    agu_top i_agu_top (
        .clk(clk), .rst_n(rst_n), .base_i(base_i), .off_src_i(off_src_i),
        .imm_i(imm_i), .idx_i(idx_i), .shamt_i(shamt_i), .add_i(add_i),
        .mode_i(mode_i), .ea_o(ea_o), .wb_val_o(wb_val_o), .wb_en_o(wb_en_o)
    );

    task automatic cmp(input string req, input logic [31:0] a_ea, input logic [31:0] a_wb,
                       input logic a_en, input logic [31:0] e_ea, input logic [31:0] e_wb,
                       input logic e_en);
        n_vec++;
        if (a_ea !== e_ea || a_wb !== e_wb || a_en !== e_en) begin
            n_bad++;
            $display("FAIL %s: got ea=%h wb=%h en=%b, expected ea=%h wb=%h en=%b",
                     req, a_ea, a_wb, a_en, e_ea, e_wb, e_en);
        end
    endtask

    // Drive one vector on a falling edge; the registered result is sampled
    // at the following falling edge, half a period after the capturing rise.
    task automatic run(input string req, input logic [31:0] b, input logic [1:0] src,
                       input logic [11:0] im, input logic [31:0] ix, input logic [1:0] sh,
                       input logic ad, input logic [1:0] md,
                       input logic [31:0] e_ea, input logic [31:0] e_wb, input logic e_en);
        @(negedge clk);
        base_i = b; off_src_i = src; imm_i = im; idx_i = ix;
        shamt_i = sh; add_i = ad; mode_i = md;
        @(negedge clk);
        cmp(req, ea_o, wb_val_o, wb_en_o, e_ea, e_wb, e_en);
    endtask

    task automatic t_reset;
        @(negedge clk);
        base_i = 32'hDEAD_BEEF; mode_i = 2'b01; idx_i = 32'h10; off_src_i = 2'b01;
        @(negedge clk);
        cmp("R9 reset", ea_o, wb_val_o, wb_en_o, 32'h0, 32'h0, 1'b0);
        rst_n = 1'b1;
    endtask

    task automatic t_offset_mode;
        run("R1 offset add", 32'h1000, 2'b00, 12'h024, 32'h0, 2'd0, 1'b1, 2'b00,
            32'h1024, 32'h1000, 1'b0);
        run("R1 offset sub", 32'h2000, 2'b01, 12'h0, 32'h100, 2'd0, 1'b0, 2'b00,
            32'h1F00, 32'h2000, 1'b0);
    endtask

    task automatic t_pre_mode;
        run("R2 pre add", 32'h4000_0000, 2'b00, 12'hFFF, 32'h0, 2'd0, 1'b1, 2'b01,
            32'h4000_0FFF, 32'h4000_0FFF, 1'b1);
        run("R2 pre sub reg", 32'h0000_0800, 2'b01, 12'h0, 32'h0000_0008, 2'd0, 1'b0, 2'b01,
            32'h0000_07F8, 32'h0000_07F8, 1'b1);
    endtask

    task automatic t_post_mode;
        run("R3 post add", 32'h2000_0800, 2'b00, 12'h004, 32'h0, 2'd0, 1'b1, 2'b10,
            32'h2000_0800, 32'h2000_0804, 1'b1);
        run("R3 post sub", 32'h0000_0100, 2'b01, 12'h0, 32'h0000_0010, 2'd0, 1'b0, 2'b10,
            32'h0000_0100, 32'h0000_00F0, 1'b1);
    endtask

    task automatic t_imm_source;
        // idx and shamt set to junk: they must not reach the sum.
        run("R4 imm zero-ext", 32'h0, 2'b00, 12'h800, 32'hFFFF_FFFF, 2'd3, 1'b1, 2'b00,
            32'h0000_0800, 32'h0, 1'b0);
    endtask

    task automatic t_reg_source;
        run("R5 reg ignores shamt", 32'h100, 2'b01, 12'hABC, 32'h0000_0004, 2'd3, 1'b1, 2'b01,
            32'h0000_0104, 32'h0000_0104, 1'b1);
    endtask

    task automatic t_shift_source;
        run("R6 shift by 2", 32'h1000, 2'b10, 12'h0, 32'h0000_0003, 2'd2, 1'b1, 2'b00,
            32'h100C, 32'h1000, 1'b0);
        run("R6 shift discards top", 32'h0, 2'b11, 12'h0, 32'hF000_0001, 2'd3, 1'b1, 2'b01,
            32'h8000_0008, 32'h8000_0008, 1'b1);
        run("R6 shift by 0", 32'h10, 2'b10, 12'h0, 32'h0000_0005, 2'd0, 1'b0, 2'b10,
            32'h10, 32'h0B, 1'b1);
    endtask

    task automatic t_wrap;
        run("R7 add wraps", 32'hFFFF_FFF0, 2'b00, 12'h020, 32'h0, 2'd0, 1'b1, 2'b01,
            32'h0000_0010, 32'h0000_0010, 1'b1);
        run("R7 sub wraps", 32'h0000_0004, 2'b00, 12'h008, 32'h0, 2'd0, 1'b0, 2'b00,
            32'hFFFF_FFFC, 32'h0000_0004, 1'b0);
    endtask

    task automatic t_reserved_mode;
        run("R8 reserved as offset", 32'h3000, 2'b00, 12'h00C, 32'h0, 2'd0, 1'b1, 2'b11,
            32'h300C, 32'h3000, 1'b0);
        run("R10 no wb in reserved", 32'h3000, 2'b01, 12'h0, 32'h4, 2'd0, 1'b0, 2'b11,
            32'h2FFC, 32'h3000, 1'b0);
    endtask

    task automatic t_latency;
        // After the capturing rise, a new input must not show until the next rise.
        run("R9 first value", 32'h500, 2'b00, 12'h001, 32'h0, 2'd0, 1'b1, 2'b00,
            32'h501, 32'h500, 1'b0);
        base_i = 32'h900; mode_i = 2'b10;
        #1;
        cmp("R9 held until edge", ea_o, wb_val_o, wb_en_o, 32'h501, 32'h500, 1'b0);
        @(negedge clk);
        cmp("R9 updated after edge", ea_o, wb_val_o, wb_en_o, 32'h900, 32'h901, 1'b1);
    endtask

    initial begin
        t_reset();
        t_offset_mode();
        t_pre_mode();
        t_post_mode();
        t_imm_source();
        t_reg_source();
        t_shift_source();
        t_wrap();
        t_reserved_mode();
        t_latency();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule